// File: doc/BRIEF.md
# Differential Clock Output Stop and Power-Down Sequencer

This block sits between a clock source and several differential output drivers. It decides, cycle by cycle, what each true/complement pair shows: the running clock, a parked level, or nothing at all. It also decides whether each leg is actively driven. It generates the output clock phase itself, at half the rate of `clk`. The true leg is that phase and the complement leg is its inverse. Two active-low request inputs may arrive with no timing relation to `clk`: a power-down request and an output-stop request.

Each request first passes through a flop synchronizer. It is then accepted only after it reads the same new value on two consecutive rising edges of the complement clock, and this applies to both assertion and release. An accepted change takes effect at the next point where the complement leg falls and the true leg rises, so no output ever shows a shortened phase.

Stop acts only on pairs marked stoppable. Power-down acts on every pair and wins over stop. Each request has its own park style: true leg held high and driven, or both legs released. A per-pair enable switches a pair off whatever the other controls say. The configuration bits come in as plain inputs.

Top module: `clkstop_seq`

## Requirements
- R1: After reset with no request active, every enabled pair has both legs driven, the true leg changes level on every `clk` cycle, and the complement leg is always its inverse.
- R2: A stop or power-down request is recognised only after two synchronizer stages and two consecutive complement-rising samples that both show the new value. A change applied just after clock edge k reaches the outputs after edge k+6 or k+7.
- R3: While stop is in force and power-down is not, pairs with `stoppable`=0 keep running as in R1.
- R4: Stop with `stop_tristate`=0 parks each enabled stoppable pair with the true leg driven at 1 and the complement leg undriven. An undriven leg always reports level 0.
- R5: Stop with `stop_tristate`=1 parks each enabled stoppable pair with both legs undriven.
- R6: Power-down parks every enabled pair, free-running ones included. With `pd_tristate`=0 the true leg is driven at 1 and the complement leg is undriven. With `pd_tristate`=1 both legs are undriven.
- R7: When both requests are in force, every pair follows the power-down park style.
- R8: After a stop release, all stoppable pairs resume in the same cycle, 4 to 12 `clk` edges (2 to 6 output periods) after the release. Their true leg is at 1 in the first resumed cycle.
- R9: A pair with `out_en`=0 has both legs undriven at level 0, whatever the requests and mode bits are.
- R10: A request pulse lasting 2 `clk` cycles is ignored, and no pair leaves the running state.
- R11: A park begins only in a cycle whose preceding true level was 0, which is where the true leg would rise anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the output clock rate |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted synchronously upstream |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| stop_req_n | input | 1 | Asynchronous output-stop request, active low |
| pd_tristate | input | 1 | Power-down park style: 0 true high driven, 1 both undriven |
| stop_tristate | input | 1 | Stop park style: 0 true high driven, 1 both undriven |
| out_en | input | N_PAIRS | Per-pair static enable |
| stoppable | input | N_PAIRS | Per-pair policy: 1 obeys stop, 0 free-running |
| tru_lvl | output | N_PAIRS | True leg level |
| tru_oe | output | N_PAIRS | True leg drive enable |
| cmp_lvl | output | N_PAIRS | Complement leg level |
| cmp_oe | output | N_PAIRS | Complement leg drive enable |

## Verification
Power-down and stop can both become accepted at the same complement-rising sample. Their parks then land on the same edge. The bench drops both request lines in one cycle, with the two park styles set to opposite values. It then checks that a stoppable pair shows the power-down style: true leg still driven. After that, power-down alone is released, and the same pair must fall back to the stop style while the free-running pair starts toggling again.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef struct packed {
    logic t_lvl;
    logic t_oe;
    logic c_lvl;
    logic c_oe;
  } pair_drv_t;

  localparam pair_drv_t DRV_OFF       = '{t_lvl: 1'b0, t_oe: 1'b0, c_lvl: 1'b0, c_oe: 1'b0};
  localparam pair_drv_t DRV_HIGH_PARK = '{t_lvl: 1'b1, t_oe: 1'b1, c_lvl: 1'b0, c_oe: 1'b0};

endpackage

// File: rtl/req_filter.sv
`timescale 1ns/1ps
module req_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_HITS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic req_n,
  output logic held_n
);
  localparam int CW = $clog2(QUAL_HITS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          hits_q, hits_d;
  logic                   held_d;
  logic                   synced_n;

  assign synced_n = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_n};
  end

  always_comb begin
    hits_d = hits_q;
    held_d = held_n;
    if (sample_en) begin
      if (synced_n == held_n) begin
        hits_d = '0;
      end else if (hits_q == CW'(QUAL_HITS - 1)) begin
        hits_d = '0;
        held_d = synced_n;
      end else begin
        hits_d = hits_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
      held_n <= 1'b1;
    end else begin
      hits_q <= hits_d;
      held_n <= held_d;
    end
  end

  // R2: the accepted value only moves on a sample that completes the run
  p_qual_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_n) |-> ($past(sample_en) && $past(hits_q) == CW'(QUAL_HITS - 1)));

endmodule

// File: rtl/pair_gate.sv
`timescale 1ns/1ps
module pair_gate
  import clkstop_pkg::*;
(
  input  logic      en,
  input  logic      can_stop,
  input  logic      phase,
  input  logic      park_pd,
  input  logic      park_stop,
  input  logic      pd_tri,
  input  logic      stop_tri,
  output pair_drv_t drv
);
  always_comb begin
    if (!en)                         drv = DRV_OFF;
    else if (park_pd)                drv = pd_tri   ? DRV_OFF : DRV_HIGH_PARK;
    else if (park_stop && can_stop)  drv = stop_tri ? DRV_OFF : DRV_HIGH_PARK;
    else                             drv = '{t_lvl: phase, t_oe: 1'b1, c_lvl: ~phase, c_oe: 1'b1};
  end

  // R4 R5 R6: an undriven leg never reports a high level
  always_comb begin
    a_undriven_low_r4: assert ((drv.t_oe || !drv.t_lvl) && (drv.c_oe || !drv.c_lvl));
  end

endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int N_PAIRS     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_HITS   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic               stop_req_n,
  input  logic               pd_tristate,
  input  logic               stop_tristate,
  input  logic [N_PAIRS-1:0] out_en,
  input  logic [N_PAIRS-1:0] stoppable,
  output logic [N_PAIRS-1:0] tru_lvl,
  output logic [N_PAIRS-1:0] tru_oe,
  output logic [N_PAIRS-1:0] cmp_lvl,
  output logic [N_PAIRS-1:0] cmp_oe
);
  logic phase_q;
  logic cmp_rise_tick, cmp_fall_tick;
  logic pd_held_n, stop_held_n;
  logic park_pd_q, park_pd_d, park_stop_q, park_stop_d;

  // next edge: phase 1->0 means complement rises, 0->1 means complement falls
  assign cmp_rise_tick = phase_q;
  assign cmp_fall_tick = ~phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  req_filter #(.SYNC_STAGES(SYNC_STAGES), .QUAL_HITS(QUAL_HITS)) u_pd_filt (
    .clk(clk), .rst_n(rst_n), .sample_en(cmp_rise_tick), .req_n(pd_req_n), .held_n(pd_held_n)
  );

  req_filter #(.SYNC_STAGES(SYNC_STAGES), .QUAL_HITS(QUAL_HITS)) u_stop_filt (
    .clk(clk), .rst_n(rst_n), .sample_en(cmp_rise_tick), .req_n(stop_req_n), .held_n(stop_held_n)
  );

  always_comb begin
    park_pd_d   = park_pd_q;
    park_stop_d = park_stop_q;
    if (cmp_fall_tick) begin
      park_pd_d   = ~pd_held_n;
      park_stop_d = ~stop_held_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_pd_q   <= 1'b0;
      park_stop_q <= 1'b0;
    end else begin
      park_pd_q   <= park_pd_d;
      park_stop_q <= park_stop_d;
    end
  end

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    pair_drv_t drv;
    pair_gate u_gate (
      .en(out_en[i]), .can_stop(stoppable[i]), .phase(phase_q),
      .park_pd(park_pd_q), .park_stop(park_stop_q),
      .pd_tri(pd_tristate), .stop_tri(stop_tristate), .drv(drv)
    );
    assign tru_lvl[i] = drv.t_lvl;
    assign tru_oe[i]  = drv.t_oe;
    assign cmp_lvl[i] = drv.c_lvl;
    assign cmp_oe[i]  = drv.c_oe;

    p_freerun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!park_pd_q && out_en[i] && !stoppable[i]) |-> (cmp_oe[i] && tru_oe[i] && (tru_lvl[i] != cmp_lvl[i])));

    p_disabled_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[i] |-> (!tru_oe[i] && !cmp_oe[i] && !tru_lvl[i] && !cmp_lvl[i]));
  end

  p_pd_all_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    park_pd_q |-> (cmp_oe == '0));

  p_park_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(park_stop_q) || $rose(park_pd_q)) |-> !$past(phase_q));

  p_resume_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(park_stop_q) && !park_pd_q) |-> ((cmp_oe & out_en) == out_en));

endmodule

// File: tb/sim_clkstop_seq.sv
`timescale 1ns/1ps
module sim_clkstop_seq;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic pd_req_n, stop_req_n, pd_tristate, stop_tristate;
  logic [N-1:0] out_en, stoppable;
  logic [N-1:0] tru_lvl, tru_oe, cmp_lvl, cmp_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  clkstop_seq #(.N_PAIRS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .stop_req_n(stop_req_n),
    .pd_tristate(pd_tristate), .stop_tristate(stop_tristate),
    .out_en(out_en), .stoppable(stoppable),
    .tru_lvl(tru_lvl), .tru_oe(tru_oe), .cmp_lvl(cmp_lvl), .cmp_oe(cmp_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // wait for cmp_oe[idx] to reach want; n = edges passed, pt = true level just before
  task automatic watch(input int idx, input logic want, output int n, output logic pt);
    n  = 0;
    pt = tru_lvl[idx];
    while (cmp_oe[idx] !== want && n < 16) begin
      pt = tru_lvl[idx];
      step(1);
      n++;
    end
  endtask

  task automatic t_reset;
    logic prev;
    rst_n = 1'b0; pd_req_n = 1'b1; stop_req_n = 1'b1;
    pd_tristate = 1'b0; stop_tristate = 1'b0;
    out_en = 4'b1111; stoppable = 4'b0110;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(tru_oe == 4'hF && cmp_oe == 4'hF, "R1 all legs driven", {tru_oe, cmp_oe}, 8'hFF);
    chk(cmp_lvl == ~tru_lvl, "R1 complement inverse", cmp_lvl, ~tru_lvl);
    prev = tru_lvl[0];
    step(1);
    chk(tru_lvl[0] != prev, "R1 true toggles", tru_lvl[0], !prev);
  endtask

  task automatic t_stop_driven;
    int n; logic pt; logic p0;
    stop_tristate = 1'b0;
    stop_req_n = 1'b0;
    watch(1, 1'b0, n, pt);
    chk(n == 6 || n == 7, "R2 stop park latency", n, 6);
    chk(pt == 1'b0, "R11 park after low phase", pt, 0);
    chk(tru_oe[1] && tru_lvl[1] && !cmp_oe[1] && !cmp_lvl[1], "R4 drive-high park pair1",
        {tru_oe[1], tru_lvl[1], cmp_oe[1], cmp_lvl[1]}, 4'b1100);
    chk(tru_oe[2] && tru_lvl[2] && !cmp_oe[2], "R4 drive-high park pair2",
        {tru_oe[2], tru_lvl[2], cmp_oe[2]}, 3'b110);
    p0 = tru_lvl[0];
    step(1);
    chk(cmp_oe[0] && cmp_oe[3] && tru_lvl[0] != p0, "R3 free-run keeps toggling",
        {cmp_oe[0], cmp_oe[3], tru_lvl[0]}, {2'b11, !p0});
    step(3);
    chk(tru_lvl[1] && tru_oe[1], "R4 park holds", {tru_oe[1], tru_lvl[1]}, 2'b11);
    stop_req_n = 1'b1;
    watch(1, 1'b1, n, pt);
    chk(n >= 4 && n <= 12, "R8 resume window", n, 6);
    chk(cmp_oe[2] && tru_oe[2], "R8 pairs resume together", {cmp_oe[2], tru_oe[2]}, 2'b11);
    chk(tru_lvl[1] && tru_lvl[2], "R8 first resumed phase high", {tru_lvl[1], tru_lvl[2]}, 2'b11);
    step(4);
  endtask

  task automatic t_pd(input logic tri_mode);
    int n; logic pt;
    pd_tristate = tri_mode;
    pd_req_n = 1'b0;
    watch(0, 1'b0, n, pt);
    chk(n == 6 || n == 7, "R2 pd park latency", n, 6);
    chk(pt == 1'b0, "R11 pd park after low phase", pt, 0);
    chk(cmp_oe == 4'h0, "R6 all complements undriven", cmp_oe, 0);
    chk(tru_oe == (tri_mode ? 4'h0 : 4'hF), "R6 true drive per mode", tru_oe, tri_mode ? 0 : 15);
    chk(tru_lvl == (tri_mode ? 4'h0 : 4'hF), "R6 true level per mode", tru_lvl, tri_mode ? 0 : 15);
    pd_req_n = 1'b1;
    step(10);
    chk(cmp_oe == 4'hF, "R6 pd released", cmp_oe, 15);
  endtask

  task automatic t_both;
    pd_tristate = 1'b0; stop_tristate = 1'b1;
    pd_req_n = 1'b0; stop_req_n = 1'b0;
    step(9);
    chk(tru_oe[1] && tru_lvl[1] && !cmp_oe[1], "R7 pd style wins on stoppable pair",
        {tru_oe[1], tru_lvl[1], cmp_oe[1]}, 3'b110);
    chk(cmp_oe == 4'h0, "R7 everything parked", cmp_oe, 0);
    pd_req_n = 1'b1;
    step(9);
    chk(!tru_oe[1] && !cmp_oe[1] && !tru_lvl[1], "R5 stop tristate park",
        {tru_oe[1], cmp_oe[1], tru_lvl[1]}, 0);
    chk(cmp_oe[0] && tru_oe[0], "R3 free-run back while stop held", {cmp_oe[0], tru_oe[0]}, 3);
    stop_req_n = 1'b1;
    step(9);
    chk(cmp_oe == 4'hF, "R8 all resumed", cmp_oe, 15);
    stop_tristate = 1'b0;
  endtask

  task automatic t_glitch;
    bit stayed = 1'b1;
    stop_req_n = 1'b0;
    step(2);
    stop_req_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (cmp_oe[1] !== 1'b1) stayed = 1'b0;
      step(1);
    end
    chk(stayed, "R10 short stop pulse ignored", stayed, 1);
  endtask

  task automatic t_disable;
    out_en = 4'b1011;
    step(1);
    chk(!tru_oe[2] && !cmp_oe[2] && !tru_lvl[2] && !cmp_lvl[2], "R9 disabled pair off",
        {tru_oe[2], cmp_oe[2], tru_lvl[2], cmp_lvl[2]}, 0);
    pd_tristate = 1'b0;
    pd_req_n = 1'b0;
    step(9);
    chk(!tru_oe[2] && tru_oe[0], "R9 disabled pair ignores pd", {tru_oe[2], tru_oe[0]}, 1);
    pd_req_n = 1'b1;
    step(10);
    chk(!cmp_oe[2] && cmp_oe[1], "R9 still off after release", {cmp_oe[2], cmp_oe[1]}, 1);
    out_en = 4'b1111;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stop_driven();
    t_pd(1'b0);
    t_pd(1'b1);
    t_both();
    t_glitch();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule